// File: doc/BRIEF.md
# Key-Protected Prescaled Watchdog Timer

This block is a watchdog peripheral on a plain 32-bit register bus. A 16-bit up-counter advances once per prescaled tick while counting is enabled. When it wraps past its all-ones value, the block does three things:
- it drives a reset request for a fixed number of cycles,
- it latches an overflow flag,
- it stops counting.

Software services the watchdog by reloading the counter. A timeout of N ticks is programmed by loading 65536 minus N. The live count can be read back at any time, so software can work out the time left.

Each register accepts a write only when the upper bits of the write data carry that register's key. Any other write is discarded without a trace. An accepted write does not take effect at once. It waits for a fixed number of cycles that models the hand-over into the counting domain, and a read-only busy bit shows this wait. While the busy bit is set, further writes are refused.

The overflow flag is not cleared by the ordinary synchronous reset, which is the reset the watchdog itself would cause. After such a reset, software can tell why the chip restarted. Only the power-on reset input, or an explicit keyed clear, removes the flag.

Top module: `keyed_wdog`

## Requirements
- R1: After the power-on reset input `por` is applied, all three registers read zero and `wdt_rst_req` is low.
- R2: A write to offset 0x0 loads `bus_wdata[15:0]` into the counter only when `bus_wdata[31:16]` is 0x5A5A. Offset 0x0 reads back the count as `{16'h0, count}`.
- R3: Writes to the control register (offset 0x4) and the scratch register (offset 0x8) take effect only when `bus_wdata[31:8]` is 0xA5A5A5, with `bus_wdata[7:0]` as payload. In the control register, bit 7 is the count enable, bit 5 is busy, bit 4 is the overflow flag and bits 2:0 are the divider code. Bits 6 and 3 read zero. Offset 0x8 stores and returns all 8 payload bits.
- R4: The following writes change no register:
  - a write whose key is wrong;
  - a write that carries the key of another register;
  - any write that arrives while busy is set.
- R5: An accepted write sets busy (control bit 5) for exactly APPLY_DLY cycles (default 3). The new value becomes visible in the same cycle that busy falls. Busy cannot be written.
- R6: Divider codes 0 to 7 give one tick every 1, 4, 16, 32, 64, 128, 1024 or 4096 cycles. The prescaler restarts whenever a control write is applied. The count holds while bit 7 is 0.
- R7: A tick at count 0xFFFF with counting enabled has these effects on the next cycle:
  - the count becomes 0;
  - the overflow flag is set;
  - the enable bit is cleared;
  - `wdt_rst_req` goes high for exactly PULSE_LEN cycles (default 4).
- R8: The overflow flag and its clearing follow these rules:
  - the synchronous reset `rst` leaves the flag unchanged;
  - a keyed control write with bit 4 = 0 clears the flag;
  - a keyed control write with bit 4 = 1 leaves the flag as it is;
  - `por` clears the flag.
- R9: Same-cycle priority:
  - a counter load applied in a tick cycle takes the load value and suppresses any overflow;
  - a control write applied in the overflow cycle still leaves the flag set and the enable clear, while its divider code is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; keeps the overflow flag |
| por | input | 1 | Synchronous power-on reset, active high; clears everything |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Byte offset: 0x0 counter, 0x4 control, 0x8 scratch |
| bus_wdata | input | 32 | Write data: key in the upper bits, payload in the lower bits |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_req | output | 1 | Reset request pulse raised on overflow |

## Verification
Two events can land on the same clock edge: a pending register update reaching its apply cycle, and a prescaler tick that either increments the counter or overflows it. The bench lines these up with cycle-exact timing. In the first case, a counter reload issued at a known cycle is applied while the counter is ticking at divider code 0. In the second case, the count is preloaded to 0xFFFC and a control write is started one cycle after enable, so that it is applied on the exact overflow edge. Each outcome is judged by reading back the count and the control register and by sampling the reset request at the predicted cycle.

// File: rtl/keyed_wdog_pkg.sv
package keyed_wdog_pkg;

    localparam int CNT_W = 16;
    localparam int PRE_W = 12;

    localparam logic [15:0] CNT_KEY  = 16'h5A5A;
    localparam logic [23:0] CTL_KEY  = 24'hA5A5A5;

    localparam logic [3:0] OFS_CNT  = 4'h0;
    localparam logic [3:0] OFS_CTLA = 4'h4;
    localparam logic [3:0] OFS_CTLB = 4'h8;

    localparam int A_EN   = 7;
    localparam int A_BUSY = 5;
    localparam int A_OVF  = 4;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_CNT  = 2'd1,
        TGT_CTLA = 2'd2,
        TGT_CTLB = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e             tgt;
        logic [CNT_W-1:0] data;
    } upd_t;

    // log2 of the prescale ratio for each divider code
    function automatic logic [3:0] div_shift(input logic [2:0] code);
        case (code)
            3'd0:    return 4'd0;
            3'd1:    return 4'd2;
            3'd2:    return 4'd4;
            3'd3:    return 4'd5;
            3'd4:    return 4'd6;
            3'd5:    return 4'd7;
            3'd6:    return 4'd10;
            default: return 4'd12;
        endcase
    endfunction

    function automatic logic [PRE_W-1:0] div_limit(input logic [2:0] code);
        logic [PRE_W:0] ratio;
        ratio = (PRE_W+1)'(1) << div_shift(code);
        return PRE_W'(ratio - 1'b1);
    endfunction

endpackage

// File: rtl/keyed_wdog_regif.sv
module keyed_wdog_regif
    import keyed_wdog_pkg::*;
#(
    parameter int APPLY_DLY = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        por,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        apply_vld,
    output upd_t        apply,
    output logic        busy
);
    localparam int DW = $clog2(APPLY_DLY + 1);

    logic          pend_vld;
    logic [DW-1:0] pend_cnt;
    upd_t          pend;
    upd_t          req;
    logic          accept;

    // key check and target decode
    always_comb begin
        req = '{tgt: TGT_NONE, data: bus_wdata[15:0]};
        if (bus_addr == OFS_CNT && bus_wdata[31:16] == CNT_KEY)
            req.tgt = TGT_CNT;
        else if (bus_addr == OFS_CTLA && bus_wdata[31:8] == CTL_KEY)
            req = '{tgt: TGT_CTLA, data: {8'h00, bus_wdata[7:0]}};
        else if (bus_addr == OFS_CTLB && bus_wdata[31:8] == CTL_KEY)
            req = '{tgt: TGT_CTLB, data: {8'h00, bus_wdata[7:0]}};
    end

    assign accept = bus_we && !pend_vld && (req.tgt != TGT_NONE);

    always_ff @(posedge clk) begin
        if (rst || por) begin
            pend_vld <= 1'b0;
            pend_cnt <= '0;
            pend     <= '{tgt: TGT_NONE, data: '0};
        end else if (accept) begin
            pend_vld <= 1'b1;
            pend_cnt <= DW'(APPLY_DLY - 1);
            pend     <= req;
        end else if (pend_vld) begin
            if (pend_cnt == '0) pend_vld <= 1'b0;
            else                pend_cnt <= pend_cnt - 1'b1;
        end
    end

    assign apply_vld = pend_vld && (pend_cnt == '0);
    assign apply     = pend;
    assign busy      = pend_vld;

    // R4
    busy_drop_chk: assert property (@(posedge clk) disable iff (rst || por)
        (busy && !apply_vld) |=> (busy && $stable(pend)));

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (rst || por)
        ($fell(busy) && !$past(rst || por)) |-> $past(apply_vld));

endmodule

// File: rtl/keyed_wdog_prescale.sv
module keyed_wdog_prescale
    import keyed_wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       por,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] div_code,
    output logic       tick
);
    logic [PRE_W-1:0] pre;

    assign tick = run && (pre == div_limit(div_code));

    always_ff @(posedge clk) begin
        if (rst || por || !run || restart) pre <= '0;
        else if (tick)                     pre <= '0;
        else                               pre <= pre + 1'b1;
    end

endmodule

// File: rtl/keyed_wdog_core.sv
module keyed_wdog_core
    import keyed_wdog_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por,
    input  logic             apply_vld,
    input  upd_t             apply,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             en,
    output logic [2:0]       div_code,
    output logic [7:0]       scratch,
    output logic             ovf,
    output logic             restart,
    output logic             rst_req
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic          load;
    logic          ovf_evt;
    logic [PW-1:0] pulse;

    assign load    = apply_vld && (apply.tgt == TGT_CNT);
    assign restart = apply_vld && (apply.tgt == TGT_CTLA);
    assign ovf_evt = tick && !load && (count == '1);

    always_ff @(posedge clk) begin
        if (rst || por) begin
            count    <= '0;
            en       <= 1'b0;
            div_code <= '0;
            scratch  <= '0;
            pulse    <= '0;
        end else begin
            if (load)      count <= apply.data;
            else if (tick) count <= count + 1'b1;

            if (restart) div_code <= apply.data[2:0];
            if (ovf_evt)      en <= 1'b0;
            else if (restart) en <= apply.data[A_EN];

            if (apply_vld && apply.tgt == TGT_CTLB) scratch <= apply.data[7:0];

            if (ovf_evt)           pulse <= PW'(PULSE_LEN);
            else if (pulse != '0)  pulse <= pulse - 1'b1;
        end
    end

    // flag survives rst; only por or an explicit clear remove it
    always_ff @(posedge clk) begin
        if (por)                                  ovf <= 1'b0;
        else if (ovf_evt && !rst)                 ovf <= 1'b1;
        else if (!rst && restart && !apply.data[A_OVF]) ovf <= 1'b0;
    end

    assign rst_req = (pulse != '0);

    logic [7:0] hi_len;
    always_ff @(posedge clk) begin
        if (rst || por)   hi_len <= '0;
        else if (rst_req) hi_len <= hi_len + 1'b1;
        else              hi_len <= '0;
    end

    // R7
    rst_len_chk: assert property (@(posedge clk) disable iff (rst || por)
        ($fell(rst_req) && !$past(rst || por)) |-> (hi_len == 8'(PULSE_LEN)));

    // R7
    ovf_stop_chk: assert property (@(posedge clk) disable iff (rst || por)
        $rose(rst_req) |-> (!en && ovf && count == '0));

    // R8
    ovf_keep_chk: assert property (@(posedge clk)
        (rst && !por && ovf) |=> ovf);

    // R6
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst || por)
        (!en && !apply_vld) |=> $stable(count));

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import keyed_wdog_pkg::*;
#(
    parameter int APPLY_DLY = 3,
    parameter int PULSE_LEN = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        por,
    input  logic        bus_we,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_rst_req
);
    logic             apply_vld;
    upd_t             apply;
    logic             busy;
    logic             tick;
    logic             restart;
    logic [CNT_W-1:0] count;
    logic             en;
    logic [2:0]       div_code;
    logic [7:0]       scratch;
    logic             ovf;

    keyed_wdog_regif #(.APPLY_DLY(APPLY_DLY)) u_regif (
        .clk(clk), .rst(rst), .por(por),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .apply_vld(apply_vld), .apply(apply), .busy(busy)
    );

    keyed_wdog_prescale u_pre (
        .clk(clk), .rst(rst), .por(por),
        .run(en), .restart(restart), .div_code(div_code), .tick(tick)
    );

    keyed_wdog_core #(.PULSE_LEN(PULSE_LEN)) u_core (
        .clk(clk), .rst(rst), .por(por),
        .apply_vld(apply_vld), .apply(apply), .tick(tick),
        .count(count), .en(en), .div_code(div_code), .scratch(scratch),
        .ovf(ovf), .restart(restart), .rst_req(wdt_rst_req)
    );

    always_comb begin
        case (bus_addr)
            OFS_CNT:  bus_rdata = {16'h0000, count};
            OFS_CTLA: bus_rdata = {24'h0, en, 1'b0, busy, ovf, 1'b0, div_code};
            OFS_CTLB: bus_rdata = {24'h0, scratch};
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/keyed_wdog_tb.sv
module keyed_wdog_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por = 1'b1;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_req;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;   // 125 MHz

    keyed_wdog dut_i (
        .clk(clk), .rst(rst), .por(por), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wdt_rst_req(wdt_rst_req)
    );

    // {wr_addr, wr_data, rd_addr, expected}
    localparam int NV = 10;
    localparam logic [71:0] VEC [NV] = '{
        {4'h0, 32'h5A5A1234, 4'h0, 32'h00001234},  // R2 keyed load
        {4'h0, 32'h5A5B9999, 4'h0, 32'h00001234},  // R4 bad key
        {4'h0, 32'hA5A5A577, 4'h0, 32'h00001234},  // R4 wrong register key
        {4'h4, 32'hA5A5A503, 4'h4, 32'h00000003},  // R3 control write
        {4'h4, 32'hA5A5A406, 4'h4, 32'h00000003},  // R4 bad key
        {4'h4, 32'h5A5A0001, 4'h4, 32'h00000003},  // R4 counter key on control
        {4'h8, 32'hA5A5A5C3, 4'h8, 32'h000000C3},  // R3 scratch
        {4'h8, 32'h0000005A, 4'h8, 32'h000000C3},  // R4 no key
        {4'h4, 32'hA5A5A527, 4'h4, 32'h00000007},  // R5 busy bit not writable
        {4'h4, 32'hA5A5A548, 4'h4, 32'h00000000}   // R3 bits 6 and 3 read zero
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] hold;
        wait_n(3);
        rst = 1'b0; por = 1'b0;

        // R1 reset state
        rd(4'h0, v); chk("R1 count", v, 32'h0);
        rd(4'h4, v); chk("R1 ctrl", v, 32'h0);
        rd(4'h8, v); chk("R1 scratch", v, 32'h0);
        chk("R1 rst_req", {31'h0, wdt_rst_req}, 32'h0);

        // R2 R3 R4 R5 table
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][71:68], VEC[i][67:36]);
            wait_n(3);
            rd(VEC[i][35:32], v);
            chk($sformatf("R2/R3/R4/R5 vec %0d", i), v, VEC[i][31:0]);
        end

        // R5 busy window of 3 cycles
        wr(4'h4, 32'hA5A5A505);
        rd(4'h4, v); chk("R5 busy set", v, 32'h20);
        wait_n(2);
        rd(4'h4, v); chk("R5 busy still", v, 32'h20);
        wait_n(1);
        rd(4'h4, v); chk("R5 applied", v, 32'h05);

        // R4 write during busy dropped
        wr(4'h8, 32'hA5A5A511);
        wr(4'h0, 32'h5A5A0777);
        wait_n(2);
        rd(4'h8, v); chk("R4 first applied", v, 32'h11);
        rd(4'h0, v); chk("R4 busy drop", v, 32'h1234);

        // R6 divider code 1 (ratio 4)
        wr(4'h0, 32'h5A5A0000); wait_n(3);
        wr(4'h4, 32'hA5A5A581); wait_n(23);
        rd(4'h0, v); chk("R6 div4 count", v, 32'h5);
        wr(4'h4, 32'hA5A5A501); wait_n(3);
        rd(4'h0, hold);
        wait_n(10);
        rd(4'h0, v); chk("R6 hold when disabled", v, hold);
        rd(4'h4, v); chk("R6 enable off", v, 32'h01);

        // R6 divider code 6 (ratio 1024)
        wr(4'h0, 32'h5A5A0000); wait_n(3);
        wr(4'h4, 32'hA5A5A586); wait_n(3 + 2048);
        rd(4'h0, v); chk("R6 div1024 count", v, 32'h2);

        // R9 load wins over tick
        wr(4'h4, 32'hA5A5A580); wait_n(3);
        wr(4'h0, 32'h5A5A0100); wait_n(5);
        rd(4'h0, v); chk("R9 load over tick", v, 32'h0102);
        wr(4'h4, 32'hA5A5A500); wait_n(3);

        // R7 overflow
        wr(4'h0, 32'h5A5AFFFE); wait_n(3);
        wr(4'h4, 32'hA5A5A580); wait_n(3);
        rd(4'h0, v); chk("R7 preload", v, 32'hFFFE);
        wait_n(2);
        chk("R7 rst_req rise", {31'h0, wdt_rst_req}, 32'h1);
        rd(4'h4, v); chk("R7 ovf set en clear", v, 32'h10);
        rd(4'h0, v); chk("R7 wrap to zero", v, 32'h0);
        wait_n(3);
        chk("R7 rst_req last", {31'h0, wdt_rst_req}, 32'h1);
        wait_n(1);
        chk("R7 rst_req end", {31'h0, wdt_rst_req}, 32'h0);
        rd(4'h0, v); chk("R7 stopped", v, 32'h0);

        // R8 flag survives rst
        rst = 1'b1; wait_n(1); rst = 1'b0;
        rd(4'h4, v); chk("R8 ovf kept", v, 32'h10);
        rd(4'h8, v); chk("R8 rst clears scratch", v, 32'h0);
        wr(4'h4, 32'hA5A5A512); wait_n(3);
        rd(4'h4, v); chk("R8 bit4 one keeps", v, 32'h12);
        wr(4'h4, 32'hA5A5A502); wait_n(3);
        rd(4'h4, v); chk("R8 bit4 zero clears", v, 32'h02);
        wr(4'h4, 32'hA5A5A512); wait_n(3);
        rd(4'h4, v); chk("R8 bit4 one no set", v, 32'h02);

        // R9 control apply in overflow cycle
        wr(4'h0, 32'h5A5AFFFC); wait_n(3);
        wr(4'h4, 32'hA5A5A580); wait_n(3);
        wr(4'h4, 32'hA5A5A585); wait_n(3);
        rd(4'h4, v); chk("R9 ovf wins, div taken", v, 32'h15);
        chk("R9 rst_req", {31'h0, wdt_rst_req}, 32'h1);
        rd(4'h0, v); chk("R9 count zero", v, 32'h0);

        // R8 por clears flag
        wait_n(5);
        por = 1'b1; wait_n(1); por = 1'b0;
        rd(4'h4, v); chk("R8 por clears", v, 32'h0);
        chk("R1 rst_req after por", {31'h0, wdt_rst_req}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule